// File: doc/BRIEF.md
# Byte Transmit Queue with Multi-Width Push

This block is the transmit side of a serial-style peripheral. It sits between a CPU register bus and a byte-wide drain port. Software loads bytes by writing one of three data registers, each of a different width. A single bus write can push one, two or four bytes, and the lowest byte is always queued first. Software can read the current fill level at any time. A downstream consumer takes bytes one at a time through a valid/ready handshake.

The interrupt tells software that the queue has just run dry. It is raised only on the cycle in which the fill level drops from one to zero. The level does not raise it, and neither does a threshold. A write that does not fit in the free space is dropped whole and sets a sticky overflow flag. No byte of a dropped write is queued.

Top module: `byte_txq`

## Requirements
- R1: After reset the fill level reads 0, `out_valid` is low, `irq` is low and the status register at offset 0x10 reads 0.
- R2: A bus write to offset 0x00 queues the byte `reg_wdata[7:0]` and raises the fill level by one.
- R3: A write to offset 0x04 queues `reg_wdata[7:0]` and then `reg_wdata[15:8]`. A write to offset 0x08 queues four bytes, from `[7:0]` up to `[31:24]`. The drain port delivers bytes in the order they were queued.
- R4: A read of offset 0x0C returns the fill level (0 to 16) in bits [4:0], with all upper bits zero.
- R5: `out_valid` is high exactly when the fill level is nonzero. A byte leaves on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` hold.
- R6: A push and a pop in the same cycle both take effect, and the fill level changes by the net amount.
- R7: A push whose byte count exceeds the free space is rejected with no byte queued. It sets the sticky overflow flag, status bit 2, which is cleared by writing 1 to that bit.
- R8: The pending flag, status bit 1 below enable, at bit 0, is set only in the cycle the fill level goes from 1 to 0. It is not set while the queue stays empty, and not when a push and a pop together hold the level at 1.
- R9: Writing 1 to status bit 0 clears the pending flag; if the flag is set in the same cycle, the set wins. Status bit 1 is a read/write interrupt enable, and `irq` equals pending AND enable.
- R10: A write to offset 0x0C, or to any unmapped offset, changes no state. Reads of the data offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Bus write strobe |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| out_valid | output | 1 | A byte is available on the drain port |
| out_data | output | 8 | Oldest queued byte |
| out_ready | input | 1 | Consumer accepts the byte this cycle |
| irq | output | 1 | Interrupt line: pending AND enable |

## Verification
The embedded assertions check four things on every cycle. The fill level never exceeds sixteen. A rejected push leaves the write pointer unmoved and sets the overflow flag. A stalled drain port holds its byte. The pending flag rises only right after a step from one to zero. Byte order across mixed widths, the net effect of a push and a pop in the same cycle, and the difference between a real drain and the queue merely staying empty are shown by the bench scenarios. The same holds for the clear-versus-set priority and for ignored writes; in each case the bench compares a queue model against the drain port and against register reads.

// File: rtl/txq_pkg.sv
// Package: shared register offsets and status bit positions for the
// byte transmit queue. Assumes 32-bit bus data and word-aligned offsets.
package txq_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_PUSH1 = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PUSH2 = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_PUSH4 = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_LEVEL = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h10;

    localparam int ST_PEND = 0;
    localparam int ST_EN   = 1;
    localparam int ST_OVF  = 2;

    localparam int MAX_LANES = 4;
endpackage

// File: rtl/txq_regif.sv
// Module: register decoder. Turns bus writes into push requests of 1, 2
// or 4 bytes and control strobes. It holds the sticky overflow flag and
// builds the combinational read data. Assumes a single-cycle write strobe.
module txq_regif
    import txq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              push_req,
    output logic [2:0]        push_cnt,
    output logic              stat_wr,
    input  logic              push_rej,
    input  logic [LVL_W-1:0]  level,
    input  logic              pending,
    input  logic              enable,
    output logic              ovf
);
    // Decode the push width from the offset.
    always_comb begin
        push_cnt = 3'd0;
        if (reg_wr) begin
            case (reg_addr)
                OFS_PUSH1: push_cnt = 3'd1;
                OFS_PUSH2: push_cnt = 3'd2;
                OFS_PUSH4: push_cnt = 3'd4;
                default:   push_cnt = 3'd0;
            endcase
        end
    end

    assign push_req = (push_cnt != 3'd0);
    assign stat_wr  = reg_wr && (reg_addr == OFS_STAT);

    // Sticky overflow flag: a rejection sets it, write-1 clears it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (push_rej)
            ovf <= 1'b1;
        else if (stat_wr && reg_wdata[ST_OVF])
            ovf <= 1'b0;
    end

    // Read multiplexer: level and status words, zero elsewhere.
    always_comb begin
        reg_rdata = 32'd0;
        case (reg_addr)
            OFS_LEVEL: reg_rdata[LVL_W-1:0] = level;
            OFS_STAT: begin
                reg_rdata[ST_PEND] = pending;
                reg_rdata[ST_EN]   = enable;
                reg_rdata[ST_OVF]  = ovf;
            end
            default: reg_rdata = 32'd0;
        endcase
    end

    // R7: a rejected push always leaves the overflow flag set.
    a_r7_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        push_rej |=> ovf);
endmodule

// File: rtl/txq_store.sv
// Module: byte ring storage with a multi-lane push and a single-byte pop.
// It accepts a push only if the whole push fits in the current free space.
// Assumes DEPTH is a power of two, so the pointers wrap on their own.
module txq_store
    import txq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [2:0]       push_cnt,
    input  logic [31:0]      push_data,
    input  logic             pop,
    output logic             push_rej,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] level_nxt,
    output logic [7:0]       head
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_acc;
    logic [LVL_W:0]   room_need;

    // The push is accepted only when level plus count stays within DEPTH.
    assign room_need = {1'b0, level} + (LVL_W+1)'(push_cnt);
    assign push_acc  = push_req && (room_need <= (LVL_W+1)'(DEPTH));
    assign push_rej  = push_req && !push_acc;

    // Net next level from the accepted push and the pop.
    assign level_nxt = level + (push_acc ? LVL_W'(push_cnt) : '0)
                             - (pop ? LVL_W'(1) : '0);

    // Write the accepted lanes, lowest byte at the lowest address.
    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_LANES; i++) begin
            if (push_acc && (i < int'(push_cnt)))
                mem[wr_ptr + PTR_W'(i)] <= push_data[8*i +: 8];
        end
    end

    // Advance the pointers and the level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_acc)
                wr_ptr <= wr_ptr + PTR_W'(push_cnt);
            if (pop)
                rd_ptr <= rd_ptr + PTR_W'(1);
            level <= level_nxt;
        end
    end

    assign head = mem[rd_ptr];

    // R4: the level never exceeds the capacity.
    a_r4_level_max: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
    // R7: a rejected push leaves the write pointer where it was.
    a_r7_no_partial: assert property (@(posedge clk) disable iff (!rst_n)
        push_rej |=> $stable(wr_ptr));
endmodule

// File: rtl/txq_irq.sv
// Module: drain-complete interrupt. It sets a sticky pending flag when the
// level steps from one to zero and gates the line with an enable bit.
// Assumes level_nxt is the value the level register takes at the next edge.
module txq_irq
    import txq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] level_nxt,
    input  logic             stat_wr,
    input  logic [31:0]      stat_wdata,
    output logic             pending,
    output logic             enable,
    output logic             irq
);
    logic drained;

    assign drained = (level == LVL_W'(1)) && (level_nxt == '0);

    // Pending flag: a drain sets it, write-1 clears it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (drained)
            pending <= 1'b1;
        else if (stat_wr && stat_wdata[ST_PEND])
            pending <= 1'b0;
    end

    // Enable bit: loaded on every status write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= 1'b0;
        else if (stat_wr)
            enable <= stat_wdata[ST_EN];
    end

    assign irq = pending && enable;

    // R8: pending rises only right after a step from one to zero.
    a_r8_pend_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> (level == '0) && ($past(level) == LVL_W'(1)));
endmodule

// File: rtl/byte_txq.sv
// Module: top of the byte transmit queue. It ties the register decoder,
// the byte storage and the interrupt logic together and presents a
// valid/ready drain port. Assumes a synchronous active-low reset.
module byte_txq
    import txq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic              irq
);
    logic             push_req;
    logic [2:0]       push_cnt;
    logic             push_rej;
    logic             stat_wr;
    logic             pop;
    logic [LVL_W-1:0] level;
    logic [LVL_W-1:0] level_nxt;
    logic             pending;
    logic             enable;
    logic             ovf;

    assign out_valid = (level != '0);
    assign pop       = out_valid && out_ready;

    txq_regif #(.LVL_W(LVL_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .push_req  (push_req),
        .push_cnt  (push_cnt),
        .stat_wr   (stat_wr),
        .push_rej  (push_rej),
        .level     (level),
        .pending   (pending),
        .enable    (enable),
        .ovf       (ovf)
    );

    txq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .push_cnt  (push_cnt),
        .push_data (reg_wdata),
        .pop       (pop),
        .push_rej  (push_rej),
        .level     (level),
        .level_nxt (level_nxt),
        .head      (out_data)
    );

    txq_irq #(.LVL_W(LVL_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .level_nxt  (level_nxt),
        .stat_wr    (stat_wr),
        .stat_wdata (reg_wdata),
        .pending    (pending),
        .enable     (enable),
        .irq        (irq)
    );

    // R5: a stalled drain port keeps its byte.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/sim_byte_txq.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a byte-queue model held in the bench.
module sim_byte_txq;
    localparam int CLK_PERIOD = 10;
    localparam int QCAP       = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = 5'h0C;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] mq[$];
    bit m_pend = 1'b0, m_en = 1'b0, m_ovf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_txq u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd(logic [4:0] a);
        if (a == 5'h0C) return 32'(mq.size());
        if (a == 5'h10) return {29'd0, m_ovf, m_en, m_pend};
        return 32'd0;
    endfunction

    function automatic int push_len(bit wr, logic [4:0] a);
        if (!wr) return 0;
        if (a == 5'h00) return 1;
        if (a == 5'h04) return 2;
        if (a == 5'h08) return 4;
        return 0;
    endfunction

    // Model update for one clock edge with the given inputs.
    task automatic model(bit wr, logic [4:0] a, logic [31:0] d, bit rdy);
        int  n   = push_len(wr, a);
        int  sz0 = mq.size();
        bit  acc = (n != 0) && (sz0 + n <= QCAP);
        bit  rej = (n != 0) && !acc;
        bit  fire;
        if (sz0 != 0 && rdy) void'(mq.pop_front());
        if (acc) for (int i = 0; i < n; i++) mq.push_back(d[8*i +: 8]);
        fire = (sz0 == 1) && (mq.size() == 0);
        if (wr && a == 5'h10) begin
            m_en = d[1];
            if (d[0]) m_pend = 1'b0;
            if (d[2]) m_ovf = 1'b0;
        end
        if (fire) m_pend = 1'b1;
        if (rej)  m_ovf = 1'b1;
    endtask

    // One cycle: drive at the falling edge, check, then advance the model.
    task automatic step(bit wr, logic [4:0] a, logic [31:0] d, bit rdy, string tag);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; out_ready = rdy;
        #1;
        chk("R5 valid", 32'(out_valid), 32'(mq.size() != 0));
        if (mq.size() != 0) chk("R3 order", 32'(out_data), 32'(mq[0]));
        chk("R9 irq", 32'(irq), 32'(m_pend & m_en));
        chk(tag, reg_rdata, exp_rd(a));
        @(posedge clk);
        model(wr, a, d, rdy);
    endtask

    task automatic idle(logic [4:0] a, bit rdy, string tag);
        step(1'b0, a, 32'd0, rdy, tag);
    endtask

    initial begin
        void'($urandom(32'h5EED_7A11));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        idle(5'h0C, 1'b0, "R1 level");
        idle(5'h10, 1'b0, "R1 status");
        // R2: single byte push, level 1
        step(1'b1, 5'h00, 32'hFFFF_FFA5, 1'b0, "R2 push");
        idle(5'h0C, 1'b0, "R2 level");
        // R3: two and four byte pushes, LSB first
        step(1'b1, 5'h04, 32'h0000_2211, 1'b0, "R3 push16");
        step(1'b1, 5'h08, 32'h6655_4433, 1'b0, "R3 push32");
        idle(5'h0C, 1'b0, "R4 level7");
        // R10: write to level and to an unmapped offset does nothing
        step(1'b1, 5'h0C, 32'hFFFF_FFFF, 1'b0, "R10 wr level");
        step(1'b1, 5'h14, 32'hFFFF_FFFF, 1'b0, "R10 wr unmapped");
        idle(5'h0C, 1'b0, "R10 level kept");
        idle(5'h08, 1'b0, "R10 data reads zero");
        // enable the interrupt
        step(1'b1, 5'h10, 32'h2, 1'b0, "R9 enable");
        // R7: fill to 15, then a 4-byte push is rejected whole
        step(1'b1, 5'h08, 32'hA3A2_A1A0, 1'b0, "R7 fill");
        step(1'b1, 5'h08, 32'hB3B2_B1B0, 1'b0, "R7 fill");
        step(1'b1, 5'h08, 32'hC3C2_C1C0, 1'b0, "R7 over");
        idle(5'h0C, 1'b0, "R7 level15");
        idle(5'h10, 1'b0, "R7 ovf set");
        step(1'b1, 5'h00, 32'h0000_00EE, 1'b0, "R7 last fits");
        idle(5'h0C, 1'b0, "R4 level16");
        step(1'b1, 5'h10, 32'h6, 1'b0, "R7 w1c");
        idle(5'h10, 1'b0, "R7 ovf cleared");
        // R6: push and pop in the same cycle on a full queue is rejected
        step(1'b1, 5'h00, 32'h77, 1'b1, "R6 full push+pop");
        idle(5'h0C, 1'b0, "R6 level15");
        // R5: stall holds, then drain to empty; R8 fires
        repeat (3) idle(5'h0C, 1'b0, "R5 stall");
        repeat (15) idle(5'h0C, 1'b1, "R5 drain");
        idle(5'h10, 1'b1, "R8 pend after drain");
        repeat (4) idle(5'h10, 1'b1, "R8 empty no refire");
        // R9: clear pending; set wins over clear on the same edge
        step(1'b1, 5'h10, 32'h3, 1'b0, "R9 clear");
        idle(5'h10, 1'b0, "R9 cleared");
        step(1'b1, 5'h00, 32'h42, 1'b0, "R8 load one");
        // R6: push and pop together hold level at 1, no interrupt
        step(1'b1, 5'h00, 32'h43, 1'b1, "R6 push+pop");
        idle(5'h0C, 1'b0, "R6 level1");
        idle(5'h10, 1'b0, "R8 no pend at 1");
        step(1'b1, 5'h10, 32'h3, 1'b1, "R9 clear vs set");
        idle(5'h10, 1'b0, "R9 set wins");
        step(1'b1, 5'h10, 32'h0, 1'b0, "R9 disable");
        idle(5'h10, 1'b0, "R9 irq gated");
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            int  sel  = int'($urandom_range(0, 9));
            int  rp   = ((k / 300) % 2 == 0) ? 3 : 7;
            bit  rdy  = ($urandom_range(0, 9) < rp);
            logic [4:0] a;
            bit  wr;
            case (sel)
                0, 1: begin wr = 1'b1; a = 5'h00; end
                2:    begin wr = 1'b1; a = 5'h04; end
                3:    begin wr = 1'b1; a = 5'h08; end
                4:    begin wr = ($urandom_range(0, 3) == 0); a = 5'h10; end
                5:    begin wr = 1'b0; a = 5'h10; end
                default: begin wr = 1'b0; a = 5'h0C; end
            endcase
            step(wr, a, $urandom, rdy, "R4 random read");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule